// File: doc/BRIEF.md
# Segment Address Translator with Protection Checks

This block turns a two-part logical address (a segment number plus an offset) into a physical address. It also enforces the protection rules held in a per-segment descriptor. The descriptor table lives in ordinary memory. Its location comes from a table-origin input, and the number of segments in use comes from a table-size input. The block reaches the table through a simple read port, which returns data one cycle after the read is issued.

Each descriptor takes two consecutive 32-bit words. The first word is the segment's physical start address. The second word holds the segment length, a present flag and three permission flags. A request first has its segment number compared against the table size, and no memory read happens if that check fails. Otherwise both descriptor words are fetched. The present flag, the offset bound and the access permission are then tested in a fixed priority. The block finishes with a one-cycle `done` pulse that carries either the translated address or a fault code.

The controller is one state machine with four states:
- `ST_IDLE`: waits for a request. It takes `ST_IDLE -> ST_FETCH_BASE` when the segment number is in range. It stays in `ST_IDLE` and reports a range fault when it is not.
- `ST_FETCH_BASE`: reads descriptor word 0, then goes to `ST_FETCH_LIMIT`.
- `ST_FETCH_LIMIT`: captures the start address and reads word 1, then goes to `ST_CHECK`.
- `ST_CHECK`: judges the descriptor and returns to `ST_IDLE`.

Top module: `segx_translate`

## Requirements
- R1: A request with segment number greater than or equal to `tbl_len` completes with fault code 1. `done` is high in the cycle after the request is sampled, and the memory port issues no read for it.
- R2: For an in-range request the block reads address `tbl_base + 8*seg` (word 0) in the cycle after acceptance, and `tbl_base + 8*seg + 4` (word 1) in the next cycle.
- R3: Word 1 holds the segment length in bits 31:4, the present flag in bit 3, read permission in bit 2, write permission in bit 1 and execute permission in bit 0. A present flag of 0 gives fault code 2.
- R4: An offset that is greater than or equal to the segment length, compared unsigned, gives fault code 3. A length of 0 therefore rejects every offset.
- R5: Access code 0 (read) needs bit 2, code 1 (write) needs bit 1 and code 2 (execute) needs bit 0. Code 3 is never permitted. A missing permission gives fault code 4.
- R6: When several checks fail, the reported code is the first failure in this order: range (1), not present (2), offset (3), permission (4).
- R7: A request that passes every check reports fault code 0 and `phys_addr` equal to word 0 plus the zero-extended offset, modulo 2^32.
- R8: For an in-range request, `done` pulses for one cycle, four cycles after the request is sampled. Whenever `done` is high with a nonzero fault code, `phys_addr` is 0.
- R9: `req_valid` is ignored while a fetched translation is in progress. The request that is in progress completes with its own operands.
- R10: During reset `done` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_seg | input | 8 | Segment number |
| req_off | input | 28 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_base | input | 32 | Byte address of descriptor 0 |
| tbl_len | input | 9 | Number of legal segments |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| done | output | 1 | One-cycle completion pulse |
| phys_addr | output | 32 | Translated address (0 on fault) |
| fault | output | 3 | 0 none, 1 range, 2 not present, 3 offset, 4 permission |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Range edge.** It probes segment number exactly equal to `tbl_len` and a table size of 0. A design with an off-by-one compare would fetch a descriptor it must not touch.
- **Offset edge.** It probes offset equal to the length and one below it, plus a zero-length segment. A signed or inclusive compare would let the last illegal byte through.
- **Combined failures.** It builds descriptors where several checks fail together. A design with the wrong priority would report offset or permission where not-present or offset is due.
- **Address wrap.** It drives start-plus-offset past 2^32 and checks that the sum wraps.
- **Reserved access code.** It checks that code 3 is always refused.
- **Back-to-back requests.** It holds `req_valid` high across a fetch with changing operands, and also sends successive out-of-range requests. These show whether a busy controller swallows or corrupts requests.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int WORD_W = 32;
    localparam int LIM_W  = WORD_W - 4;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_SEGNUM  = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_OFFSET  = 3'd3,
        FLT_PRIV    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_BASE,
        ST_FETCH_LIMIT,
        ST_CHECK
    } walk_st_e;

    typedef struct packed {
        logic [LIM_W-1:0] limit;
        logic             valid;
        logic             rd;
        logic             wr;
        logic             ex;
    } attr_t;

endpackage

// File: rtl/segx_attr_decode.sv
module segx_attr_decode
    import segx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output attr_t             attr
);

    // Descriptor word 1: length | present | read | write | execute
    always_comb begin
        attr.limit = word[WORD_W-1:4];
        attr.valid = word[3];
        attr.rd    = word[2];
        attr.wr    = word[1];
        attr.ex    = word[0];
    end

endmodule

// File: rtl/segx_rule_check.sv
module segx_rule_check
    import segx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  attr_t             attr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LIM_W-1:0]  off,
    input  acc_e              acc,
    output fault_e            chk_fault,
    output logic [ADDR_W-1:0] chk_phys
);

    logic allowed;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = attr.rd;
            ACC_WRITE: allowed = attr.wr;
            ACC_EXEC:  allowed = attr.ex;
            ACC_RSVD:  allowed = 1'b0;
        endcase
    end

    // Fixed priority: present, then bound, then permission
    always_comb begin
        if (!attr.valid)
            chk_fault = FLT_INVALID;
        else if (off >= attr.limit)
            chk_fault = FLT_OFFSET;
        else if (!allowed)
            chk_fault = FLT_PRIV;
        else
            chk_fault = FLT_NONE;
    end

    assign chk_phys = (chk_fault == FLT_NONE) ? (seg_base + ADDR_W'(off)) : '0;

endmodule

// File: rtl/segx_walk_fsm.sv
module segx_walk_fsm
    import segx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [LIM_W-1:0]  req_off,
    input  acc_e              req_acc,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic [ADDR_W-1:0] seg_base_q,
    output logic [LIM_W-1:0]  off_q,
    output acc_e              acc_q,
    output logic              checking,
    input  fault_e            chk_fault,
    input  logic [ADDR_W-1:0] chk_phys,
    output logic              done_q,
    output fault_e            fault_q,
    output logic [ADDR_W-1:0] phys_q
);

    localparam int LEN_W      = SEG_W + 1;
    localparam int ENTRY_SH   = 3;
    localparam int WORD_BYTES = WORD_W / 8;

    walk_st_e            state_q, state_d;
    logic [SEG_W-1:0]    seg_q;
    logic [LEN_W-1:0]    len_q;
    logic [ADDR_W-1:0]   tbl_q;
    logic [ADDR_W-1:0]   entry_addr;
    logic                in_range;

    assign in_range   = {1'b0, req_seg} < tbl_len;
    assign entry_addr = tbl_q + (ADDR_W'(seg_q) << ENTRY_SH);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid && in_range) state_d = ST_FETCH_BASE;
            ST_FETCH_BASE:  state_d = ST_FETCH_LIMIT;
            ST_FETCH_LIMIT: state_d = ST_CHECK;
            ST_CHECK:       state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_rd_addr = entry_addr;
        checking    = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_FETCH_BASE:  mem_rd_en = 1'b1;
            ST_FETCH_LIMIT: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = entry_addr + ADDR_W'(WORD_BYTES);
            end
            ST_CHECK:       checking = 1'b1;
        endcase
    end

    // Operand capture, descriptor base capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q      <= '0;
            len_q      <= '0;
            tbl_q      <= '0;
            off_q      <= '0;
            acc_q      <= ACC_READ;
            seg_base_q <= '0;
            done_q     <= 1'b0;
            fault_q    <= FLT_NONE;
            phys_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        seg_q <= req_seg;
                        len_q <= tbl_len;
                        tbl_q <= tbl_base;
                        off_q <= req_off;
                        acc_q <= req_acc;
                        if (!in_range) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_SEGNUM;
                            phys_q  <= '0;
                        end
                    end
                end
                ST_FETCH_BASE:  ;
                ST_FETCH_LIMIT: seg_base_q <= mem_rd_data[ADDR_W-1:0];
                ST_CHECK: begin
                    done_q  <= 1'b1;
                    fault_q <= chk_fault;
                    phys_q  <= chk_phys;
                end
            endcase
        end
    end

    // R1: the table is only read for a segment number below the size
    p_fetch_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ({1'b0, seg_q} < len_q));

    // R2: the word-1 read directly follows the word-0 read, four bytes on
    p_limit_word_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_BASE) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(WORD_BYTES)));

    // R8: a faulted completion never exposes an address
    p_no_phys_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && fault_q != FLT_NONE) |-> (phys_q == '0));

    // R9: latched operands stay put while a translation is in flight
    p_operands_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(seg_q) && $stable(off_q) && $stable(acc_q)));

endmodule

// File: rtl/segx_translate.sv
module segx_translate
    import segx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [27:0]       req_off,
    input  logic [1:0]        req_acc,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [2:0]        fault
);

    attr_t             attr;
    logic [ADDR_W-1:0] seg_base_q;
    logic [LIM_W-1:0]  off_q;
    acc_e              acc_q;
    logic              checking;
    fault_e            chk_fault;
    logic [ADDR_W-1:0] chk_phys;
    fault_e            fault_q;

    segx_walk_fsm #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_seg     (req_seg),
        .req_off     (req_off),
        .req_acc     (acc_e'(req_acc)),
        .tbl_base    (tbl_base),
        .tbl_len     (tbl_len),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .seg_base_q  (seg_base_q),
        .off_q       (off_q),
        .acc_q       (acc_q),
        .checking    (checking),
        .chk_fault   (chk_fault),
        .chk_phys    (chk_phys),
        .done_q      (done),
        .fault_q     (fault_q),
        .phys_q      (phys_addr)
    );

    segx_attr_decode u_decode (
        .word (mem_rd_data),
        .attr (attr)
    );

    segx_rule_check #(.ADDR_W(ADDR_W)) u_check (
        .attr      (attr),
        .seg_base  (seg_base_q),
        .off       (off_q),
        .acc       (acc_q),
        .chk_fault (chk_fault),
        .chk_phys  (chk_phys)
    );

    assign fault = fault_q;

    // R4: a passing verdict implies the offset is inside the length
    p_pass_within_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && chk_fault == FLT_NONE) |-> (off_q < attr.limit));

    // R6: an absent descriptor outranks every later check
    p_absent_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && !attr.valid) |-> (chk_fault == FLT_INVALID));

    // R5: the reserved access code never passes
    p_reserved_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && acc_q == ACC_RSVD) |-> (chk_fault != FLT_NONE));

    // R8: completion codes stay within the defined set
    p_fault_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault <= 3'd4));

endmodule

// File: tb/tb_segx_translate.sv
module tb_segx_translate;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TBL_ORG = 32'h0000_0200;
    localparam int MEM_WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_seg = '0;
    logic [27:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] tbl_base = TBL_ORG;
    logic [8:0]  tbl_len = 9'd8;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        done;
    logic [31:0] phys_addr;
    logic [2:0]  fault;

    logic [31:0] mem [0:MEM_WORDS-1];

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    segx_translate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done(done), .phys_addr(phys_addr), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] idx;
        idx = (a - TBL_ORG) >> 2;
        if (a < TBL_ORG || idx >= MEM_WORDS) return 32'hDEAD_BEEF;
        return mem[idx[5:0]];
    endfunction

    // word1: length[31:4] present[3] read[2] write[1] execute[0]
    function automatic logic [31:0] mk_attr(input logic [27:0] lim, input logic v,
                                            input logic r, input logic w, input logic x);
        return {lim, v, r, w, x};
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd0: return "R7";
            3'd1: return "R1";
            3'd2: return "R3";
            3'd3: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Table read port: one cycle latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);

    // Behavioural reference
    int          pend = 0;
    logic        exp_done = 1'b0;
    logic [2:0]  exp_fault = '0;
    logic [31:0] exp_phys = '0;
    logic [2:0]  hold_fault;
    logic [31:0] hold_phys;
    logic [31:0] hold_addr = '0;

    task automatic judge(input int seg, input logic [27:0] off, input logic [1:0] acc,
                         output logic [2:0] f, output logic [31:0] p);
        logic [31:0] w0, w1;
        logic ok;
        w0 = mem_word(tbl_base + 32'(seg) * 8);
        w1 = mem_word(tbl_base + 32'(seg) * 8 + 4);
        case (acc)
            2'd0: ok = w1[2];
            2'd1: ok = w1[1];
            2'd2: ok = w1[0];
            default: ok = 1'b0;
        endcase
        p = 32'd0;
        if (!w1[3]) f = 3'd2;
        else if ({4'd0, off} >= (w1 >> 4)) f = 3'd3;
        else if (!ok) f = 3'd4;
        else begin f = 3'd0; p = w0 + {4'd0, off}; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pend = 0;
            exp_done = 1'b0;
        end else begin
            exp_done = 1'b0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) begin
                    exp_done = 1'b1; exp_fault = hold_fault; exp_phys = hold_phys;
                end
            end else if (req_valid) begin
                if ({1'b0, req_seg} >= tbl_len) begin
                    exp_done = 1'b1; exp_fault = 3'd1; exp_phys = '0;
                end else begin
                    judge(int'(req_seg), req_off, req_acc, hold_fault, hold_phys);
                    hold_addr = tbl_base + 32'(req_seg) * 8;
                    pend = 3;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8", "done", 32'(done), 32'(exp_done));
            chk((pend >= 2) ? "R2" : "R1", "mem_rd_en", 32'(mem_rd_en), 32'(pend >= 2));
            if (pend == 3) chk("R2", "word0 addr", mem_rd_addr, hold_addr);
            if (pend == 2) chk("R2", "word1 addr", mem_rd_addr, hold_addr + 4);
            if (exp_done) begin
                chk(tag_of(exp_fault), "fault", 32'(fault), 32'(exp_fault));
                chk((exp_fault != 0) ? "R8" : "R7", "phys_addr", phys_addr, exp_phys);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input int seg, input logic [27:0] off, input logic [1:0] acc);
        @(negedge clk);
        req_valid = 1'b1; req_seg = 8'(seg); req_off = off; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
        mem[0]  = 32'h1000_0000; mem[1]  = mk_attr(28'h100, 1, 1, 1, 1);
        mem[2]  = 32'h0000_1100; mem[3]  = mk_attr(28'h0,   0, 1, 1, 1);
        mem[4]  = 32'h0000_2000; mem[5]  = mk_attr(28'h0,   1, 1, 1, 1);
        mem[6]  = 32'hFFFF_FF00; mem[7]  = mk_attr(28'hFFF_FFFF, 1, 1, 0, 0);
        mem[8]  = 32'h0000_4000; mem[9]  = mk_attr(28'h10,  1, 0, 0, 1);
        mem[10] = 32'h0000_5000; mem[11] = mk_attr(28'h20,  1, 0, 1, 0);
        mem[12] = 32'h0000_6000; mem[13] = mk_attr(28'h0,   0, 0, 0, 0);
        mem[14] = 32'h0000_7000; mem[15] = mk_attr(28'h4,   1, 0, 0, 0);
        for (int i = 8; i < 32; i++) begin
            mem[2*i]   = 32'h0010_0000 + 32'(i) * 32'h100;
            mem[2*i+1] = mk_attr(28'(i * 3), 1, 1, 1, 1);
        end

        // R10: quiet outputs during reset
        repeat (3) @(negedge clk);
        chk("R10", "done in reset", 32'(done), 32'd0);
        chk("R10", "rd_en in reset", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(8, 28'h0, 2'd0);        // R1: seg equal to size
        issue(200, 28'h0, 2'd0);      // R1: far out of range
        issue(0, 28'h0, 2'd0);        // R7: first byte
        issue(0, 28'hFF, 2'd0);       // R4: last legal byte
        issue(0, 28'h100, 2'd0);      // R4: offset equals length
        issue(0, 28'h10, 2'd1);       // R5: write allowed
        issue(0, 28'h10, 2'd2);       // R5: execute allowed
        issue(0, 28'h10, 2'd3);       // R5: reserved code refused
        issue(1, 28'h0, 2'd0);        // R3: not present
        issue(6, 28'hFFF_FFFF, 2'd3); // R6: absent wins over bound and permission
        issue(2, 28'h0, 2'd0);        // R4: zero length
        issue(3, 28'h200, 2'd0);      // R7: sum wraps past 2^32
        issue(3, 28'h200, 2'd1);      // R5: write denied
        issue(4, 28'h8, 2'd2);        // R5: execute only
        issue(4, 28'h8, 2'd0);        // R5: read denied
        issue(5, 28'h1F, 2'd1);       // R5: write only
        issue(5, 28'h1F, 2'd2);       // R5: execute denied
        issue(7, 28'hA, 2'd0);        // R6: bound outranks permission
        issue(7, 28'h1, 2'd0);        // R5: permission last
        for (int s = 8; s < 32; s += 5) issue(s, 28'(s), 2'd1);

        // R9: request held through a fetch with changing operands
        tbl_len = 9'd32;
        @(negedge clk);
        req_valid = 1'b1; req_seg = 8'd9; req_off = 28'd2; req_acc = 2'd0;
        @(negedge clk); req_seg = 8'd1; req_off = 28'd99;
        @(negedge clk); req_seg = 8'd2;
        @(negedge clk); req_valid = 1'b0;
        repeat (8) @(negedge clk);

        // R1: back-to-back range faults, then an empty table
        req_valid = 1'b1; req_seg = 8'd40;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        tbl_len = 9'd0;
        issue(0, 28'h0, 2'd0);
        tbl_len = 9'd8;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule